// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master and the two phase ticks that a byte engine needs to move data: one in the middle of each clock-low phase, when SDA may change, and one in the middle of each clock-high phase, when SDA is sampled. A single 32-bit divider word sets the phase lengths. Its lower half gives the low-phase length and its upper half gives the high-phase length, each counted in units of eight input clocks. The SCL rate is therefore the input clock divided by eight times the sum of the two halves. When both halves equal d, one SCL period is 16·d input clocks.

The generator also forms the bus START and STOP conditions. It drives an SDA pull-down request during those conditions, and it raises a one-cycle completion pulse when a STOP has finished. It runs only while the controller enable and the transfer-active input are both high. Dropping either one returns it to the released idle state. A new divider value is picked up only when a START begins and at the start of each low phase, so a bit that is already on the wire is never cut short.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, while idle, and on the clock edge after either `ctl_en` or `xfer_act` is low, `scl_o` is 1, `sda_pull` is 0 and both ticks are 0.
- R2: A `start_req` sampled while idle and running holds `scl_o`=1 with `sda_pull`=1 for 4·H cycles, then a low phase begins. A `start_req` at any other time has no effect.
- R3: Each low phase holds `scl_o`=0 for exactly 8·L cycles, where L is `div_word[15:0]`.
- R4: Each high phase holds `scl_o`=1 for exactly 8·H cycles, where H is `div_word[31:16]`.
- R5: A half value of 0 behaves exactly like a value of 1.
- R6: `tick_chg` is high for one cycle in each data low phase, in the cycle that has 4·L cycles of that phase before it. It is never high in any other phase.
- R7: `tick_smp` is high for one cycle in each data high phase, in the cycle that has 4·H cycles of that phase before it. It is never high in any other phase.
- R8: `div_word` is sampled when a START is accepted and in the first cycle of every low phase. A change at any other time does not alter the phase in progress.
- R9: A `stop_req` seen during START, a low phase or a high phase takes effect when the current high phase ends. A low phase of 8·L cycles with `sda_pull`=1 follows. Then `scl_o`=1 with `sda_pull`=1 for 4·H cycles, with `stop_done`=1 in the last of those cycles. After that the block is idle.
- R10: A `stop_req` while idle or during a STOP sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable |
| xfer_act | input | 1 | Transfer active |
| div_word | input | 32 | [31:16] high-phase half, [15:0] low-phase half, in units of 8 clocks |
| start_req | input | 1 | Request a START condition |
| stop_req | input | 1 | Request a STOP after the current bit |
| scl_o | output | 1 | 1 = SCL released high, 0 = SCL pulled low |
| sda_pull | output | 1 | 1 = pull SDA low for START/STOP |
| tick_chg | output | 1 | Mid-low pulse: SDA may change |
| tick_smp | output | 1 | Mid-high pulse: sample SDA |
| stop_done | output | 1 | Last cycle of a STOP sequence |

## Verification
The outputs are compared every cycle against a bench model that counts elapsed cycles upward and derives the phase lengths from the requirements. Equal small halves check the basic period and tick placement. Strongly unequal halves (long low, one-unit high) show whether the two halves are swapped or combined. All-zero halves show the clamp to one. Random divider rewrites during a transfer tell apart sampling at the start of a low phase from sampling at any other time. A STOP raised during START, a STOP raised while idle, a START raised mid-transfer and a transfer-active drop show which requests are ignored and how the block aborts.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  localparam int unsigned SCL_HALF_W   = 16;
  localparam int unsigned SCL_SCALE_LG = 3;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_START     = 3'd1,
    PH_LOW       = 3'd2,
    PH_HIGH      = 3'd3,
    PH_STOP_LOW  = 3'd4,
    PH_STOP_HIGH = 3'd5
  } scl_phase_e;

  // last down-count value of a whole phase: (half << lg) - 1
  function automatic int unsigned full_last(int unsigned half, int unsigned lg);
    return (half << lg) - 1;
  endfunction

  // last down-count value of half a phase; also the midpoint count
  function automatic int unsigned half_last(int unsigned half, int unsigned lg);
    return (half << (lg - 1)) - 1;
  endfunction

endpackage

// File: rtl/i2c_scl_divlatch.sv
module i2c_scl_divlatch #(
  parameter int unsigned HALF_W = i2c_scl_pkg::SCL_HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [2*HALF_W-1:0] div_word,
  output logic [HALF_W-1:0] eff_lo,
  output logic [HALF_W-1:0] eff_hi
);

  logic [HALF_W-1:0] raw_lo, raw_hi, lat_lo, lat_hi;

  // a zero half counts as one unit
  assign raw_lo = (div_word[HALF_W-1:0] == '0) ? HALF_W'(1) : div_word[HALF_W-1:0];
  assign raw_hi = (div_word[2*HALF_W-1:HALF_W] == '0) ? HALF_W'(1) : div_word[2*HALF_W-1:HALF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo <= HALF_W'(1);
      lat_hi <= HALF_W'(1);
    end else if (take) begin
      lat_lo <= raw_lo;
      lat_hi <= raw_hi;
    end
  end

  // bypass so the phase being loaded uses the freshly sampled value
  assign eff_lo = take ? raw_lo : lat_lo;
  assign eff_hi = take ? raw_hi : lat_hi;

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(lat_lo) && $stable(lat_hi))); // R8
  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_lo != '0) && (eff_hi != '0)); // R5

endmodule

// File: rtl/i2c_scl_phasecnt.sv
module i2c_scl_phasecnt #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign at_end = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R4

endmodule

// File: rtl/i2c_scl_seq.sv
module i2c_scl_seq
  import i2c_scl_pkg::*;
#(
  parameter int unsigned HALF_W   = SCL_HALF_W,
  parameter int unsigned SCALE_LG = SCL_SCALE_LG,
  localparam int unsigned CNT_W   = HALF_W + SCALE_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              at_end,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [HALF_W-1:0] eff_lo,
  input  logic [HALF_W-1:0] eff_hi,
  output logic              take,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              scl_o,
  output logic              sda_pull,
  output logic              tick_chg,
  output logic              tick_smp,
  output logic              stop_done
);

  scl_phase_e phase, nxt;
  logic stop_pend;

  always_comb begin
    nxt      = phase;
    take     = 1'b0;
    load     = 1'b0;
    load_val = '0;
    if (!run) begin
      nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (start_req) begin
          nxt = PH_START; take = 1'b1; load = 1'b1;
          load_val = CNT_W'(half_last(32'(eff_hi), SCALE_LG));
        end
        PH_START: if (at_end) begin
          nxt = PH_LOW; take = 1'b1; load = 1'b1;
          load_val = CNT_W'(full_last(32'(eff_lo), SCALE_LG));
        end
        PH_LOW: if (at_end) begin
          nxt = PH_HIGH; load = 1'b1;
          load_val = CNT_W'(full_last(32'(eff_hi), SCALE_LG));
        end
        PH_HIGH: if (at_end) begin
          nxt = (stop_pend || stop_req) ? PH_STOP_LOW : PH_LOW;
          take = 1'b1; load = 1'b1;
          load_val = CNT_W'(full_last(32'(eff_lo), SCALE_LG));
        end
        PH_STOP_LOW: if (at_end) begin
          nxt = PH_STOP_HIGH; load = 1'b1;
          load_val = CNT_W'(half_last(32'(eff_hi), SCALE_LG));
        end
        PH_STOP_HIGH: if (at_end) nxt = PH_IDLE;
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      stop_pend <= 1'b0;
    else if (nxt == PH_STOP_LOW || nxt == PH_IDLE)
      stop_pend <= 1'b0;
    else if (stop_req && (phase == PH_START || phase == PH_LOW || phase == PH_HIGH))
      stop_pend <= 1'b1;
  end

  assign scl_o     = !(phase == PH_LOW || phase == PH_STOP_LOW);
  assign sda_pull  = (phase == PH_START) || (phase == PH_STOP_LOW) || (phase == PH_STOP_HIGH);
  assign tick_chg  = (phase == PH_LOW)  && (cnt == CNT_W'(half_last(32'(eff_lo), SCALE_LG)));
  assign tick_smp  = (phase == PH_HIGH) && (cnt == CNT_W'(half_last(32'(eff_hi), SCALE_LG)));
  assign stop_done = (phase == PH_STOP_HIGH) && at_end && run;

  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_chg && tick_smp)); // R6
  AST_CHG_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick_chg |-> !scl_o && !sda_pull); // R6
  AST_SMP_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tick_smp |-> scl_o && !sda_pull); // R7
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !sda_pull && !tick_chg && !tick_smp)); // R1
  AST_START_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && run && start_req) |=> (sda_pull && scl_o)); // R2
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> (!sda_pull && scl_o)); // R9

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int unsigned HALF_W   = SCL_HALF_W,
  parameter int unsigned SCALE_LG = SCL_SCALE_LG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic                xfer_act,
  input  logic [2*HALF_W-1:0] div_word,
  input  logic                start_req,
  input  logic                stop_req,
  output logic                scl_o,
  output logic                sda_pull,
  output logic                tick_chg,
  output logic                tick_smp,
  output logic                stop_done
);

  localparam int unsigned CNT_W = HALF_W + SCALE_LG;

  logic              run, take, load, at_end;
  logic [CNT_W-1:0]  load_val, cnt;
  logic [HALF_W-1:0] eff_lo, eff_hi;

  assign run = ctl_en && xfer_act;

  i2c_scl_divlatch #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .take(take), .div_word(div_word),
    .eff_lo(eff_lo), .eff_hi(eff_hi)
  );

  i2c_scl_phasecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .cnt(cnt), .at_end(at_end)
  );

  i2c_scl_seq #(.HALF_W(HALF_W), .SCALE_LG(SCALE_LG)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .start_req(start_req),
    .stop_req(stop_req), .at_end(at_end), .cnt(cnt),
    .eff_lo(eff_lo), .eff_hi(eff_hi), .take(take), .load(load),
    .load_val(load_val), .scl_o(scl_o), .sda_pull(sda_pull),
    .tick_chg(tick_chg), .tick_smp(tick_smp), .stop_done(stop_done)
  );

endmodule

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_en = 1'b0, xfer_act = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic [31:0] div_word = 32'h0002_0002;
  logic scl_o, sda_pull, tick_chg, tick_smp, stop_done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string scen = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_scl_timer uut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .xfer_act(xfer_act),
    .div_word(div_word), .start_req(start_req), .stop_req(stop_req),
    .scl_o(scl_o), .sda_pull(sda_pull), .tick_chg(tick_chg),
    .tick_smp(tick_smp), .stop_done(stop_done)
  );

  // ---------------- reference model: elapsed cycles counted upward
  int m_st = 0, m_el = 0, m_lo = 1, m_hi = 1;
  bit m_pend = 0;

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int phase_len(int st, int lo, int hi);
    case (st)
      1: return 4 * hi;
      2: return 8 * lo;
      3: return 8 * hi;
      4: return 8 * lo;
      5: return 4 * hi;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_el <= 0; m_lo <= 1; m_hi <= 1; m_pend <= 0;
    end else if (!(ctl_en && xfer_act)) begin
      m_st <= 0; m_el <= 0; m_pend <= 0;
    end else if (m_st == 0) begin
      m_pend <= 0;
      if (start_req) begin
        m_st <= 1; m_el <= 0;
        m_lo <= clamp1(int'(div_word[15:0]));
        m_hi <= clamp1(int'(div_word[31:16]));
      end
    end else begin
      if (stop_req && m_st >= 1 && m_st <= 3) m_pend <= 1;
      if (m_el == phase_len(m_st, m_lo, m_hi) - 1) begin
        m_el <= 0;
        case (m_st)
          1: begin
            m_st <= 2;
            m_lo <= clamp1(int'(div_word[15:0])); m_hi <= clamp1(int'(div_word[31:16]));
          end
          2: m_st <= 3;
          3: begin
            m_lo <= clamp1(int'(div_word[15:0])); m_hi <= clamp1(int'(div_word[31:16]));
            if (m_pend || stop_req) begin m_st <= 4; m_pend <= 0; end
            else m_st <= 2;
          end
          4: m_st <= 5;
          default: begin m_st <= 0; m_pend <= 0; end
        endcase
      end else begin
        m_el <= m_el + 1;
      end
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0b expected=%0b at cycle %0d", tag, scen, what, act, exp, cyc);
    end
  endtask

  function automatic string st_tag(int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(st_tag(m_st), "scl_o", scl_o, (m_st == 0 || m_st == 1 || m_st == 3 || m_st == 5));
      chk(st_tag(m_st), "sda_pull", sda_pull, (m_st == 1 || m_st == 4 || m_st == 5));
      chk("R6", "tick_chg", tick_chg, (m_st == 2 && m_el == 4 * m_lo));
      chk("R7", "tick_smp", tick_smp, (m_st == 3 && m_el == 4 * m_hi));
      chk("R9", "stop_done", stop_done, (m_st == 5 && m_el == 4 * m_hi - 1));
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (m_st != 0);
  endtask

  // one transfer: nb data bits, optional divider rewrites and a stray START
  task automatic xfer(int lo, int hi, int nb, bit chg, bit stray);
    int seen = 0;
    @(negedge clk);
    div_word = {16'(hi), 16'(lo)};
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    while (seen < nb) begin
      @(negedge clk);
      start_req = 1'b0;
      if (tick_chg && chg) div_word = {16'($urandom_range(0, 5)), 16'($urandom_range(0, 5))};
      if (tick_chg && stray) start_req = 1'b1;
      if (tick_smp) seen++;
    end
    stop_req = 1'b1;
    start_req = 1'b0;
    @(negedge clk);
    stop_req = 1'b0;
    wait_idle();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset scl_o", scl_o, 1'b1);
    chk("R1", "reset sda_pull", sda_pull, 1'b0);
    chk("R1", "reset tick_chg", tick_chg, 1'b0);
    chk("R1", "reset tick_smp", tick_smp, 1'b0);
    rst_n = 1'b1;
    // R1/R2: start while disabled is ignored
    start_req = 1'b1; xfer_act = 1'b1;
    @(negedge clk);
    start_req = 1'b0; ctl_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "start while disabled scl_o", scl_o, 1'b1);
    chk("R2", "start while disabled sda_pull", sda_pull, 1'b0);

    scen = "R3"; xfer(2, 2, 3, 0, 0);
    scen = "R4"; xfer(16, 1, 2, 0, 0);
    scen = "R4"; xfer(1, 7, 2, 0, 0);
    scen = "R5"; xfer(0, 0, 3, 0, 0);
    scen = "R8"; xfer(3, 2, 6, 1, 0);
    scen = "R2"; xfer(2, 3, 3, 0, 1);

    // R10: stop while idle ignored
    scen = "R10";
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "idle after stray stop sda_pull", sda_pull, 1'b0);
    chk("R10", "idle after stray stop scl_o", scl_o, 1'b1);

    // R9: stop raised during START phase, start and stop together
    scen = "R9";
    @(negedge clk); div_word = 32'h0002_0001; start_req = 1'b1; stop_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    @(negedge clk); stop_req = 1'b0;
    wait_idle();

    // R1: abort by dropping xfer_act mid-transfer
    scen = "R1";
    @(negedge clk); div_word = 32'h0003_0002; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (30) @(negedge clk);
    xfer_act = 1'b0;
    @(negedge clk);
    chk("R1", "abort scl_o", scl_o, 1'b1);
    chk("R1", "abort sda_pull", sda_pull, 1'b0);
    @(negedge clk); xfer_act = 1'b1;
    repeat (4) @(negedge clk);

    // random transfers
    for (int k = 0; k < 40; k++) begin
      scen = (k % 2 == 0) ? "R8" : "R5";
      xfer(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
           int'($urandom_range(1, 4)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule